// File: doc/BRIEF.md
# Request-Paced Single-Channel Byte Mover

A single channel that copies bytes from memory to one fixed peripheral data-register address. Each request from the peripheral moves exactly one byte. The channel reads the byte at the current source address, writes it to the destination address and then acknowledges the request. After every byte the source address advances by one.

Software loads the source address, the destination address and the byte count while the channel is disabled. It then sets the enable bit. As bytes move, a remaining-count register counts down. A half-way flag sets once the remaining count reaches half of the programmed count, and a done flag sets after the last byte. Each flag has its own interrupt enable. When the last byte has moved, the channel clears its enable bit and ignores any later requests. Setting the enable bit again re-arms it with the programmed values.

Registers sit at word addresses on a 3-bit register address:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Source address |
| 2 | Destination address |
| 3 | Count |
| 4 | Status (read) |
| 5 | Flag clear (write) |

Top module: `pdma_channel`

## Requirements
- R1: After reset the control, status and count reads are zero, `irq_o`, `mem_req_o`, `per_we_o` and `dack_o` are low.
- R2: While the channel is enabled with a nonzero remaining count, a high `dreq_i` causes one memory read at the current source address. This is followed by exactly one `per_we_o` pulse that carries the byte read and the programmed destination address. `dack_o` is high for one cycle, in the cycle right after that write. The current source address (read at address 1) then advances by 1.
- R3: Reading address 3 returns the remaining count, which falls by 1 per acknowledged byte. Writing 1 to the enable bit (control bit 0) while it is 0 reloads the remaining count from the programmed count and the current source address from the programmed source.
- R4: The half-way flag (status bit 0) sets after the transfer that makes the remaining count equal to floor(count/2), and it stays set.
- R5: After the final byte, the done flag (status bit 1) sets and the enable bit reads 0.
- R6: Requests while the channel is disabled or has completed cause no memory read, no peripheral write and no acknowledge.
- R7: Writes to addresses 1, 2 and 3 are ignored while the enable bit is 1.
- R8: Writing 1 to bit 0 or bit 1 of address 5 clears only the matching status flag; writing 0 leaves that flag unchanged.
- R9: `irq_o` is high exactly when (half-way flag and control bit 1) or (done flag and control bit 2).
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` returns, for any read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 8 | Memory read data |
| per_we_o | output | 1 | Peripheral write strobe |
| per_addr_o | output | AW | Peripheral write address |
| per_wdata_o | output | 8 | Peripheral write data |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Request acknowledge |
| irq_o | output | 1 | Channel interrupt |

## Verification
The hardest case to reach is a request that arrives after the count has run out. The bench only gets there by driving every handshake of a full transfer first. It therefore sweeps counts 1 to 10, drives one request per byte and checks the count, both flags and the interrupt after each byte. It then holds `dreq_i` high for many cycles and confirms that no write and no acknowledge appear. Memory latency varies with the count, so the address-hold rule is tested with zero to three wait cycles.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_READ, XS_WRITE, XS_ACK} xfer_state_e;

  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_SRC  = 3'd1;
  localparam logic [REG_AW-1:0] RA_DST  = 3'd2;
  localparam logic [REG_AW-1:0] RA_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd4;
  localparam logic [REG_AW-1:0] RA_CLR  = 3'd5;

  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_HIE = 1;
  localparam int unsigned CB_TIE = 2;
  localparam int unsigned SB_HT  = 0;
  localparam int unsigned SB_TC  = 1;
endpackage

// File: rtl/pdma_regs.sv
`timescale 1ns/1ps
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              step_i,
  output logic              en_o,
  output logic [AW-1:0]     cur_src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     rem_o,
  output logic              ht_o,
  output logic              tc_o,
  output logic              irq_o
);
  logic          en_q, hie_q, tie_q, ht_q, tc_q;
  logic [AW-1:0] src_base_q, cur_src_q, dst_q;
  logic [CW-1:0] len_q, rem_q;

  logic          wr_ctrl, wr_src, wr_dst, wr_cnt, wr_clr, step_ok;
  logic [CW-1:0] half_pt, rem_nxt;

  assign wr_ctrl = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_src  = reg_we_i && (reg_addr_i == RA_SRC) && !en_q;
  assign wr_dst  = reg_we_i && (reg_addr_i == RA_DST) && !en_q;
  assign wr_cnt  = reg_we_i && (reg_addr_i == RA_CNT) && !en_q;
  assign wr_clr  = reg_we_i && (reg_addr_i == RA_CLR);
  assign step_ok = step_i && (rem_q != '0);
  assign half_pt = len_q >> 1;
  assign rem_nxt = rem_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      hie_q      <= 1'b0;
      tie_q      <= 1'b0;
      ht_q       <= 1'b0;
      tc_q       <= 1'b0;
      src_base_q <= '0;
      cur_src_q  <= '0;
      dst_q      <= '0;
      len_q      <= '0;
      rem_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        hie_q <= reg_wdata_i[CB_HIE];
        tie_q <= reg_wdata_i[CB_TIE];
        if (reg_wdata_i[CB_EN] && !en_q) begin
          en_q      <= 1'b1;
          cur_src_q <= src_base_q;
          rem_q     <= len_q;
        end else if (!reg_wdata_i[CB_EN]) begin
          en_q <= 1'b0;
        end
      end
      if (wr_src) begin
        src_base_q <= reg_wdata_i[AW-1:0];
        cur_src_q  <= reg_wdata_i[AW-1:0];
      end
      if (wr_dst) dst_q <= reg_wdata_i[AW-1:0];
      if (wr_cnt) begin
        len_q <= reg_wdata_i[CW-1:0];
        rem_q <= reg_wdata_i[CW-1:0];
      end
      if (wr_clr) begin
        if (reg_wdata_i[SB_HT]) ht_q <= 1'b0;
        if (reg_wdata_i[SB_TC]) tc_q <= 1'b0;
      end
      // progress updates win over software in the same cycle
      if (step_ok) begin
        cur_src_q <= cur_src_q + 1'b1;
        rem_q     <= rem_nxt;
        if (rem_nxt == half_pt) ht_q <= 1'b1;
        if (rem_nxt == '0) begin
          tc_q <= 1'b1;
          en_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[CB_EN]  = en_q;
        reg_rdata_o[CB_HIE] = hie_q;
        reg_rdata_o[CB_TIE] = tie_q;
      end
      RA_SRC:  reg_rdata_o[AW-1:0] = cur_src_q;
      RA_DST:  reg_rdata_o[AW-1:0] = dst_q;
      RA_CNT:  reg_rdata_o[CW-1:0] = rem_q;
      RA_STAT: begin
        reg_rdata_o[SB_HT] = ht_q;
        reg_rdata_o[SB_TC] = tc_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign cur_src_o = cur_src_q;
  assign dst_o     = dst_q;
  assign rem_o     = rem_q;
  assign ht_o      = ht_q;
  assign tc_o      = tc_q;
  assign irq_o     = (ht_q && hie_q) || (tc_q && tie_q);
endmodule

// File: rtl/pdma_xfer.sv
`timescale 1ns/1ps
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          dreq_i,
  input  logic [AW-1:0] cur_src_i,
  input  logic [AW-1:0] dst_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          per_we_o,
  output logic [AW-1:0] per_addr_o,
  output logic [DW-1:0] per_wdata_o,
  output logic          dack_o,
  output logic          step_o
);
  xfer_state_e   state_q, state_d;
  logic [DW-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:  if (active_i && dreq_i) state_d = XS_READ;
      XS_READ:  if (mem_rvalid_i) state_d = XS_WRITE;
      XS_WRITE: state_d = XS_ACK;
      XS_ACK:   state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XS_READ && mem_rvalid_i) data_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (state_q == XS_READ);
  assign mem_addr_o  = cur_src_i;
  assign per_we_o    = (state_q == XS_WRITE);
  assign per_addr_o  = dst_i;
  assign per_wdata_o = data_q;
  // ack only after the single write has gone out
  assign dack_o      = (state_q == XS_ACK);
  assign step_o      = (state_q == XS_ACK);
endmodule

// File: rtl/pdma_channel.sv
`timescale 1ns/1ps
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              per_we_o,
  output logic [AW-1:0]     per_addr_o,
  output logic [DW-1:0]     per_wdata_o,
  input  logic              dreq_i,
  output logic              dack_o,
  output logic              irq_o
);
  logic          en_w, ht_w, tc_w, step_w, active_w;
  logic [AW-1:0] cur_src_w, dst_w;
  logic [CW-1:0] rem_w;

  assign active_w = en_w && (rem_w != '0);

  pdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .step_i      (step_w),
    .en_o        (en_w),
    .cur_src_o   (cur_src_w),
    .dst_o       (dst_w),
    .rem_o       (rem_w),
    .ht_o        (ht_w),
    .tc_o        (tc_w),
    .irq_o       (irq_o)
  );

  pdma_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active_w),
    .dreq_i       (dreq_i),
    .cur_src_i    (cur_src_w),
    .dst_i        (dst_w),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .per_we_o     (per_we_o),
    .per_addr_o   (per_addr_o),
    .per_wdata_o  (per_wdata_o),
    .dack_o       (dack_o),
    .step_o       (step_w)
  );
endmodule

// File: rtl/pdma_channel_chk.sv
`timescale 1ns/1ps
module pdma_channel_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          per_we_o,
  input logic          dack_o,
  input logic          dreq_i,
  input logic          en_i,
  input logic          tc_i
);
  AST_ACK_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> $past(per_we_o)); // R2
  AST_WRITE_THEN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_we_o |=> dack_o); // R2
  AST_SINGLE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, per_we_o, dack_o})); // R2
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10
  AST_REQ_PACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(dreq_i && en_i)); // R6
  AST_DONE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_i) |-> !en_i); // R5
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .per_we_o     (per_we_o),
  .dack_o       (dack_o),
  .dreq_i       (dreq_i),
  .en_i         (en_w),
  .tc_i         (tc_w)
);

// File: tb/tb_pdma_channel.sv
`timescale 1ns/1ps
module tb_pdma_channel;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          per_we;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;
  logic          dreq = 1'b0;
  logic          dack, irq;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, ack_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  int mem_lat = 0, wcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdma_channel dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .per_we_o(per_we), .per_addr_o(per_addr), .per_wdata_o(per_wdata),
    .dreq_i(dreq), .dack_o(dack), .irq_o(irq)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory with programmable wait cycles
  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) begin
      if (wcnt == mem_lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_f(mem_addr);
        wcnt       <= 0;
        rd_cnt     <= rd_cnt + 1;
      end else wcnt <= wcnt + 1;
    end else mem_rvalid <= 1'b0;
  end

  always @(posedge clk) begin
    if (per_we) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= per_addr;
      wr_data <= per_wdata;
    end
    if (dack) ack_cnt <= ack_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_req(output bit ok);
    ok = 0;
    @(negedge clk);
    dreq = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dack) begin ok = 1; break; end
    end
    dreq = 1'b0;
  endtask

  task automatic idle_req(input string tag);
    int w0, a0, r0;
    w0 = wr_cnt; a0 = ack_cnt; r0 = rd_cnt;
    @(negedge clk);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    @(negedge clk);
    chk({tag, " writes"}, wr_cnt, w0);
    chk({tag, " acks"}, ack_cnt, a0);
    chk({tag, " reads"}, rd_cnt, r0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd0, rd); chk("R1 ctrl", rd, 0);
    reg_rd(3'd4, rd); chk("R1 status", rd, 0);
    reg_rd(3'd3, rd); chk("R1 count", rd, 0);
    chk("R1 outputs", {irq, mem_req, per_we, dack}, 4'b0);

    // R6 request while disabled
    reg_wr(3'd1, 32'h0200); reg_wr(3'd2, 32'h5000); reg_wr(3'd3, 32'd4);
    idle_req("R6 disabled");

    // main sweep over count and memory latency
    for (int len = 1; len <= 10; len++) begin
      logic [AW-1:0] src, dst;
      logic hie, tie;
      src = AW'(16'h0100 * len + 16'h00FC);
      dst = AW'(16'h4000 + len);
      hie = len[0];
      tie = len[1];
      mem_lat = len % 4;
      reg_wr(3'd0, 0);
      reg_wr(3'd5, 3);
      reg_wr(3'd1, 32'(src));
      reg_wr(3'd2, 32'(dst));
      reg_wr(3'd3, 32'(len));
      reg_wr(3'd0, {29'b0, tie, hie, 1'b1});
      for (int k = 1; k <= len; k++) begin
        int w0;
        logic ht_e, tc_e;
        w0 = wr_cnt;
        do_req(ok);
        chk("R2 ack", 32'(ok), 1);
        chk("R2 one write", wr_cnt, w0 + 1);
        chk("R2 dst", 32'(wr_addr), 32'(dst));
        chk(mem_lat > 0 ? "R10 data" : "R2 data", 32'(wr_data), 32'(mem_f(src + AW'(k - 1))));
        reg_rd(3'd1, rd); chk("R2 src step", rd, 32'(src + AW'(k)));
        reg_rd(3'd3, rd); chk("R3 remaining", rd, 32'(len - k));
        ht_e = (len - k) <= (len / 2);
        tc_e = (k == len);
        reg_rd(3'd4, rd);
        chk("R4 half", 32'(rd[0]), 32'(ht_e));
        chk("R5 done", 32'(rd[1]), 32'(tc_e));
        chk("R9 irq", 32'(irq), 32'((ht_e & hie) | (tc_e & tie)));
      end
      reg_rd(3'd0, rd); chk("R5 enable cleared", rd, {29'b0, tie, hie, 1'b0});
      idle_req("R6 after done");
    end

    // R7 config lock, R3 re-arm
    mem_lat = 0;
    reg_wr(3'd0, 0);
    reg_wr(3'd5, 3);
    reg_wr(3'd1, 32'h0300); reg_wr(3'd2, 32'h6000); reg_wr(3'd3, 32'd4);
    reg_wr(3'd0, 1);
    reg_wr(3'd3, 32'd9); reg_wr(3'd1, 32'h0777); reg_wr(3'd2, 32'h6666);
    reg_rd(3'd3, rd); chk("R7 count locked", rd, 4);
    reg_rd(3'd1, rd); chk("R7 src locked", rd, 32'h0300);
    reg_rd(3'd2, rd); chk("R7 dst locked", rd, 32'h6000);
    reg_wr(3'd0, 1); // already enabled: no reload
    do_req(ok); do_req(ok);
    reg_rd(3'd3, rd); chk("R3 remaining mid", rd, 2);
    do_req(ok); do_req(ok);
    reg_rd(3'd4, rd); chk("R5 done rearm case", rd, 3);
    reg_wr(3'd0, 1);
    reg_rd(3'd3, rd); chk("R3 reload count", rd, 4);
    reg_rd(3'd1, rd); chk("R3 reload src", rd, 32'h0300);
    do_req(ok);
    chk("R3 rearmed write", 32'(wr_data), 32'(mem_f(16'h0300)));

    // R8 selective clear
    reg_wr(3'd5, 32'h0);
    reg_rd(3'd4, rd); chk("R8 zero write", rd, 3);
    reg_wr(3'd5, 32'h1);
    reg_rd(3'd4, rd); chk("R8 clear half only", rd, 2);
    reg_wr(3'd5, 32'h2);
    reg_rd(3'd4, rd); chk("R8 clear done", rd, 0);

    // R9 enables alone
    reg_wr(3'd0, 32'h6);
    chk("R9 no flags", 32'(irq), 0);

    finish_run();
  end
endmodule